// File: doc/BRIEF.md
# SIMD Lane Element Store Sequencer

This block takes one decoded single-structure vector element store and turns it into a sequence of memory write requests. A command presents the instruction fields: the lane selector bits Q and S, the two-bit size field, the three-bit opcode, the R bit, the first vector register number Rt and the base register number Rn. The block works out the element width and the lane from these fields, or reports an undefined encoding. It then reads one 128-bit vector register per element and issues one byte-addressed write per cycle. Each write moves on only after the memory side accepts it.

The element count is one to four. Each element comes from the next vector register, with the register number wrapping from 31 back to 0. Each element is written to the next consecutive address, so the addresses step by the element's byte count. A base register number of 31 selects the stack pointer rather than a general-purpose register. In that case the stack pointer must be 16-byte aligned or no writes are issued. Every write carries a release-ordering flag, so a downstream memory model can enforce ordering.

Top module: `lane_store_seq`

## Requirements
- R1: A legal command issues exactly {opcode[0],R}+1 writes. Write s goes to base + s*bytes, where bytes is the element byte count, and wrBytes carries that count as the value 1, 2, 4 or 8.
- R2: opcode[2:1]=00 stores a byte element. Its lane index is {Q,S,size[1:0]} (0 to 15), and wrData[7:0] holds byte number index of the register.
- R3: opcode[2:1]=01 stores a halfword element with lane index {Q,S,size[1]}, starting at register byte 2*index. The encoding is undefined when size[0]=1.
- R4: opcode[2:1]=10 with size[1]=1 is undefined. With size=00, a word element is stored with lane index {Q,S}, starting at register byte 4*index.
- R5: opcode[2:1]=10 with size=01 stores a doubleword element with lane index Q, starting at register byte 8*Q. The encoding is undefined when S=1.
- R6: opcode[2:1]=11 is always undefined for this store.
- R7: Element s is read from vector register (Rt+s) mod 32 through vrAddr. The element sits in the low bits of wrData, and the unused upper bits are zero.
- R8: When Rn=31 the base is spData, and if spData[3:0] is not zero, alignFault pulses for one cycle and no write is issued. When Rn is below 31 the base is the gpData value returned for gpAddr=Rn, and no alignment check applies.
- R9: A request holds wrValid, wrAddr, wrData and wrBytes steady until wrReady. wrRelease is 1 on every request. done pulses one cycle after the last write is accepted.
- R10: An undefined encoding raises undefFlag for the one cycle after the command is accepted, issues no write and leaves cmdReady high. Undefined takes priority over an alignment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Idle, ready to take a command |
| cmdQ | input | 1 | Q lane selector bit |
| cmdS | input | 1 | S lane selector bit |
| cmdSize | input | 2 | size field |
| cmdOpcode | input | 3 | opcode field (scale and count bit) |
| cmdR | input | 1 | R count bit |
| cmdRt | input | 5 | First vector register number |
| cmdRn | input | 5 | Base register number, 31 selects the stack pointer |
| gpAddr | output | 5 | General-purpose register read address |
| gpData | input | 64 | General-purpose register read data |
| spData | input | 64 | Stack pointer value |
| vrAddr | output | 5 | Vector register read address |
| vrData | input | 128 | Vector register read data |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write request accepted |
| wrAddr | output | 64 | Write byte address |
| wrData | output | 64 | Element data, low-aligned |
| wrBytes | output | 4 | Byte count of the write |
| wrRelease | output | 1 | Release-ordering flag |
| undefFlag | output | 1 | Undefined encoding pulse |
| alignFault | output | 1 | Stack pointer misalignment pulse |
| done | output | 1 | Sequence complete pulse |

## Verification
The bench uses the default parameters: 64-bit addresses, 128-bit vector registers, 32 registers and 16-byte stack alignment. With these values, random base addresses can carry past the top of the address space. A misaligned stack pointer can have any of its four low bits set. Start registers near 31 exercise the wrap to register 0 with four-element sequences. Random ready stalls exercise request holding at every element.

// File: rtl/lane_store_pkg.sv
package lane_store_pkg;

  // Byte offset of a lane inside one vector register.
  localparam int LANE_OFS_W = 4;

  typedef struct packed {
    logic load;     // capture a legal command
    logic advance;  // step to the next element
  } seqStrobe_t;

  typedef struct packed {
    logic                  undef;
    logic [1:0]            scale;     // log2 of element bytes
    logic [LANE_OFS_W-1:0] laneByte;  // first register byte of the element
    logic [1:0]            lastIdx;   // element count minus one
  } elemDecode_t;

  function automatic elemDecode_t decodeElem(
    input logic       q,
    input logic       s,
    input logic [1:0] size,
    input logic [2:0] opcode,
    input logic       r
  );
    elemDecode_t d;
    d = '0;
    d.lastIdx = {opcode[0], r};
    case (opcode[2:1])
      2'b00: begin
        d.scale    = 2'd0;
        d.laneByte = {q, s, size};
      end
      2'b01: begin
        d.undef    = size[0];
        d.scale    = 2'd1;
        d.laneByte = {q, s, size[1], 1'b0};
      end
      2'b10: begin
        if (size[1]) begin
          d.undef = 1'b1;
        end else if (!size[0]) begin
          d.scale    = 2'd2;
          d.laneByte = {q, s, 2'b00};
        end else begin
          d.undef    = s;
          d.scale    = 2'd3;
          d.laneByte = {q, 3'b000};
        end
      end
      default: d.undef = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lane_store_dp.sv
module lane_store_dp
  import lane_store_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VREG_W    = 128,
  parameter int REG_IDX_W = 5,
  parameter int SP_ALIGN  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 cmdQ,
  input  logic                 cmdS,
  input  logic [1:0]           cmdSize,
  input  logic [2:0]           cmdOpcode,
  input  logic                 cmdR,
  input  logic [REG_IDX_W-1:0] cmdRt,
  input  logic [REG_IDX_W-1:0] cmdRn,
  input  logic [ADDR_W-1:0]    gpData,
  input  logic [ADDR_W-1:0]    spData,
  input  logic [VREG_W-1:0]    vrData,
  output logic [REG_IDX_W-1:0] gpAddr,
  output logic [REG_IDX_W-1:0] vrAddr,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [63:0]          wrData,
  output logic [3:0]           wrBytes,
  output logic                 decUndef,
  output logic                 decMisaligned,
  output logic                 lastElem
);

  localparam int ALIGN_LSB = $clog2(SP_ALIGN);
  localparam logic [REG_IDX_W-1:0] SP_SEL = '1;

  elemDecode_t               dec;
  logic                      useSp;
  logic [ADDR_W-1:0]         baseSel;
  logic [ADDR_W-1:0]         curAddr;
  logic [REG_IDX_W-1:0]      curT;
  logic [1:0]                remaining;
  logic [1:0]                scaleR;
  logic [LANE_OFS_W-1:0]     laneByteR;
  logic [VREG_W-1:0]         shifted;

  assign dec           = decodeElem(cmdQ, cmdS, cmdSize, cmdOpcode, cmdR);
  assign decUndef      = dec.undef;
  assign gpAddr        = cmdRn;
  assign useSp         = (cmdRn == SP_SEL);
  assign baseSel       = useSp ? spData : gpData;
  assign decMisaligned = useSp && (|baseSel[ALIGN_LSB-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      curT      <= '0;
      remaining <= '0;
      scaleR    <= '0;
      laneByteR <= '0;
    end else if (strobe.load) begin
      curAddr   <= baseSel;
      curT      <= cmdRt;
      remaining <= dec.lastIdx;
      scaleR    <= dec.scale;
      laneByteR <= dec.laneByte;
    end else if (strobe.advance) begin
      curAddr   <= curAddr + ADDR_W'(wrBytes);
      curT      <= curT + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  assign vrAddr   = curT;
  assign wrAddr   = curAddr;
  assign wrBytes  = 4'd1 << scaleR;
  assign lastElem = (remaining == 2'd0);
  assign shifted  = vrData >> {laneByteR, 3'b000};

  always_comb begin
    case (scaleR)
      2'd0:    wrData = {56'd0, shifted[7:0]};
      2'd1:    wrData = {48'd0, shifted[15:0]};
      2'd2:    wrData = {32'd0, shifted[31:0]};
      default: wrData = shifted[63:0];
    endcase
  end

  // R2..R5: every loaded lane lies wholly inside the register
  a_r2_lane_fits: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ({1'b0, laneByteR} + {1'b0, wrBytes}) <= 5'd16);

  // R7: register number steps by one, wrapping, on each advance
  a_r7_reg_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> vrAddr == REG_IDX_W'($past(vrAddr) + 1'b1));

endmodule

// File: rtl/lane_store_ctrl.sv
module lane_store_ctrl
  import lane_store_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       decUndef,
  input  logic       decMisaligned,
  input  logic       lastElem,
  input  logic       wrReady,
  output logic       cmdReady,
  output logic       wrValid,
  output seqStrobe_t strobe,
  output logic       undefFlag,
  output logic       alignFault,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_ISSUE} seqState_t;

  seqState_t state;
  logic      accept;
  logic      finish;

  assign cmdReady       = (state == ST_IDLE);
  assign wrValid        = (state == ST_ISSUE);
  assign accept         = cmdValid && cmdReady;
  assign finish         = wrValid && wrReady && lastElem;
  assign strobe.load    = accept && !decUndef && !decMisaligned;
  assign strobe.advance = wrValid && wrReady && !lastElem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      undefFlag  <= 1'b0;
      alignFault <= 1'b0;
      done       <= 1'b0;
    end else begin
      undefFlag  <= accept && decUndef;
      alignFault <= accept && !decUndef && decMisaligned;
      done       <= finish;
      if (strobe.load)  state <= ST_ISSUE;
      else if (finish)  state <= ST_IDLE;
    end
  end

  // R10: at most one status pulse per cycle
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({undefFlag, alignFault, done}));

  // R10: undefined command leaves the block idle
  a_r10_undef_idle: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> cmdReady && !wrValid);

  // R9: done only follows acceptance of the last element
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrValid && wrReady && lastElem));

endmodule

// File: rtl/lane_store_seq.sv
module lane_store_seq
  import lane_store_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VREG_W   = 128,
  parameter int REG_CNT  = 32,
  parameter int SP_ALIGN = 16,
  localparam int REG_IDX_W = $clog2(REG_CNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic                 cmdQ,
  input  logic                 cmdS,
  input  logic [1:0]           cmdSize,
  input  logic [2:0]           cmdOpcode,
  input  logic                 cmdR,
  input  logic [REG_IDX_W-1:0] cmdRt,
  input  logic [REG_IDX_W-1:0] cmdRn,
  output logic [REG_IDX_W-1:0] gpAddr,
  input  logic [ADDR_W-1:0]    gpData,
  input  logic [ADDR_W-1:0]    spData,
  output logic [REG_IDX_W-1:0] vrAddr,
  input  logic [VREG_W-1:0]    vrData,
  output logic                 wrValid,
  input  logic                 wrReady,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [63:0]          wrData,
  output logic [3:0]           wrBytes,
  output logic                 wrRelease,
  output logic                 undefFlag,
  output logic                 alignFault,
  output logic                 done
);

  seqStrobe_t strobe;
  logic       decUndef;
  logic       decMisaligned;
  logic       lastElem;

  lane_store_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .decUndef     (decUndef),
    .decMisaligned(decMisaligned),
    .lastElem     (lastElem),
    .wrReady      (wrReady),
    .cmdReady     (cmdReady),
    .wrValid      (wrValid),
    .strobe       (strobe),
    .undefFlag    (undefFlag),
    .alignFault   (alignFault),
    .done         (done)
  );

  lane_store_dp #(
    .ADDR_W   (ADDR_W),
    .VREG_W   (VREG_W),
    .REG_IDX_W(REG_IDX_W),
    .SP_ALIGN (SP_ALIGN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdQ         (cmdQ),
    .cmdS         (cmdS),
    .cmdSize      (cmdSize),
    .cmdOpcode    (cmdOpcode),
    .cmdR         (cmdR),
    .cmdRt        (cmdRt),
    .cmdRn        (cmdRn),
    .gpData       (gpData),
    .spData       (spData),
    .vrData       (vrData),
    .gpAddr       (gpAddr),
    .vrAddr       (vrAddr),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .wrBytes      (wrBytes),
    .decUndef     (decUndef),
    .decMisaligned(decMisaligned),
    .lastElem     (lastElem)
  );

  assign wrRelease = wrValid;

  // R9: a stalled request keeps its contents
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrBytes));

  // R1: next address is previous plus the element byte count
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrReady && !lastElem |=> wrAddr == $past(wrAddr) + ADDR_W'($past(wrBytes)));

  // R8: an alignment fault never coincides with a write
  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !wrValid);

endmodule

// File: tb/lane_store_seq_test.sv
module lane_store_seq_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdReady;
  logic         cmdQ = 1'b0, cmdS = 1'b0, cmdR = 1'b0;
  logic [1:0]   cmdSize = '0;
  logic [2:0]   cmdOpcode = '0;
  logic [4:0]   cmdRt = '0, cmdRn = '0;
  logic [4:0]   gpAddr, vrAddr;
  logic [63:0]  gpData, spData;
  logic [127:0] vrData;
  logic         wrValid, wrReady = 1'b0;
  logic [63:0]  wrAddr, wrData;
  logic [3:0]   wrBytes;
  logic         wrRelease, undefFlag, alignFault, done;
  logic [63:0]  gpVal = 64'h0, spVal = 64'h0;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_store_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdQ(cmdQ), .cmdS(cmdS), .cmdSize(cmdSize), .cmdOpcode(cmdOpcode),
    .cmdR(cmdR), .cmdRt(cmdRt), .cmdRn(cmdRn), .gpAddr(gpAddr),
    .gpData(gpData), .spData(spData), .vrAddr(vrAddr), .vrData(vrData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .wrBytes(wrBytes), .wrRelease(wrRelease), .undefFlag(undefFlag),
    .alignFault(alignFault), .done(done)
  );

  function automatic logic [7:0] vbyte(input int r, input int k);
    return 8'(r * 29 + k * 7 + 90);
  endfunction

  always_comb begin
    for (int k = 0; k < 16; k++) vrData[k*8 +: 8] = vbyte(int'(vrAddr), k);
  end
  assign gpData = gpVal + 64'(gpAddr);
  assign spData = spVal;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected decode from the requirement text
  function automatic void expDecode(input bit q, input bit s, input bit [1:0] size,
      input bit [2:0] op, output bit undef, output int bytes, output int lane);
    undef = 0; bytes = 1; lane = 0;
    if (op[2:1] == 2'b00) begin bytes = 1; lane = {q, s, size}; end
    else if (op[2:1] == 2'b01) begin undef = size[0]; bytes = 2; lane = 2 * {q, s, size[1]}; end
    else if (op[2:1] == 2'b10) begin
      if (size[1]) undef = 1;
      else if (!size[0]) begin bytes = 4; lane = 4 * {q, s}; end
      else begin undef = s; bytes = 8; lane = 8 * q; end
    end else undef = 1;
  endfunction

  function automatic logic [63:0] expElem(input int r, input int lane, input int bytes);
    logic [63:0] v = '0;
    for (int k = 0; k < bytes; k++) v |= 64'(vbyte(r, lane + k)) << (k * 8);
    return v;
  endfunction

  task automatic runCmd(input bit q, input bit s, input bit [1:0] size, input bit [2:0] op,
      input bit r, input bit [4:0] rt, input bit [4:0] rn, input int stallPct);
    bit undef; int bytes, lane, cnt, sIdx, guard;
    logic [63:0] base;
    expDecode(q, s, size, op, undef, bytes, lane);
    cnt  = int'({op[0], r}) + 1;
    base = (rn == 5'd31) ? spVal : gpVal + 64'(rn);
    @(negedge clk);
    cmdQ = q; cmdS = s; cmdSize = size; cmdOpcode = op; cmdR = r;
    cmdRt = rt; cmdRn = rn; cmdValid = 1'b1; wrReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    if (undef) begin
      check(undefFlag === 1'b1, "R10 undefFlag", 64'(undefFlag), 64'd1);
      check(wrValid === 1'b0 && cmdReady === 1'b1 && alignFault === 1'b0,
            "R10 no write", 64'(wrValid), 64'd0);
      if (op[2:1] == 2'b11) check(undefFlag === 1'b1, "R6 scale11 undef", 64'(undefFlag), 64'd1);
      return;
    end
    if (rn == 5'd31 && base[3:0] != 4'd0) begin
      check(alignFault === 1'b1 && wrValid === 1'b0, "R8 align fault", 64'(alignFault), 64'd1);
      return;
    end
    check(undefFlag === 1'b0 && alignFault === 1'b0, "R8 no flag", 64'({undefFlag, alignFault}), 64'd0);
    sIdx = 0;
    guard = 0;
    while (sIdx < cnt && guard < 200) begin
      bit rdy;
      guard++;
      if (wrValid !== 1'b1) begin
        check(1'b0, "R9 wrValid held", 64'(wrValid), 64'd1);
        break;
      end
      rdy = ($urandom % 100) >= stallPct;
      if (rdy) begin
        logic [63:0] eAddr = base + 64'(sIdx * bytes);
        logic [63:0] eData = expElem((int'(rt) + sIdx) % 32, lane, bytes);
        check(wrAddr === eAddr, "R1 address", wrAddr, eAddr);
        check(wrData === eData, "R7 element data R2", wrData, eData);
        check(wrBytes === 4'(bytes), "R1 byte count", 64'(wrBytes), 64'(bytes));
        check(vrAddr === 5'(int'(rt) + sIdx), "R7 reg wrap", 64'(vrAddr), 64'(5'(int'(rt) + sIdx)));
        check(wrRelease === 1'b1, "R9 release flag", 64'(wrRelease), 64'd1);
        sIdx++;
      end
      wrReady = rdy;
      @(posedge clk);
      @(negedge clk);
    end
    wrReady = 1'b0;
    check(done === 1'b1 && wrValid === 1'b0, "R9 done pulse", 64'({done, wrValid}), 64'b10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady === 1'b1 && wrValid === 1'b0 && done === 1'b0 && undefFlag === 1'b0,
          "R9 reset state", 64'({cmdReady, wrValid, done, undefFlag}), 64'b1000);
    gpVal = 64'h0000_1234_5678_9000;
    spVal = 64'h0000_7FFF_FFF0_0000;
    // R2 byte lanes, top and bottom
    runCmd(1, 1, 2'b11, 3'b000, 0, 5'd3, 5'd4, 0);
    runCmd(0, 0, 2'b00, 3'b000, 1, 5'd9, 5'd0, 30);
    // R3 halfword, legal and undefined
    runCmd(1, 0, 2'b10, 3'b010, 0, 5'd7, 5'd2, 0);
    runCmd(0, 1, 2'b01, 3'b011, 1, 5'd7, 5'd2, 0);
    // R4 word, legal and undefined
    runCmd(1, 1, 2'b00, 3'b100, 1, 5'd1, 5'd5, 50);
    runCmd(0, 0, 2'b10, 3'b100, 0, 5'd1, 5'd5, 0);
    // R5 doubleword, legal and undefined
    runCmd(1, 0, 2'b01, 3'b101, 1, 5'd12, 5'd6, 20);
    runCmd(0, 1, 2'b01, 3'b100, 0, 5'd12, 5'd6, 0);
    // R6 replicate scale
    runCmd(0, 0, 2'b00, 3'b110, 0, 5'd0, 5'd0, 0);
    // R7 register wrap with four elements
    runCmd(0, 1, 2'b10, 3'b001, 1, 5'd30, 5'd8, 40);
    // R8 stack pointer aligned, then misaligned, then undef priority
    runCmd(1, 0, 2'b11, 3'b001, 1, 5'd4, 5'd31, 0);
    spVal = 64'h0000_7FFF_FFF0_0008;
    runCmd(0, 0, 2'b00, 3'b000, 0, 5'd4, 5'd31, 0);
    runCmd(0, 0, 2'b00, 3'b111, 0, 5'd4, 5'd31, 0);
    // R1 address carry past the top of the space
    gpVal = 64'hFFFF_FFFF_FFFF_FFF0;
    runCmd(1, 0, 2'b01, 3'b101, 1, 5'd31, 5'd3, 0);
    for (int i = 0; i < 300; i++) begin
      gpVal = {$urandom, $urandom};
      spVal = {$urandom, $urandom};
      if ($urandom % 4 != 0) spVal[3:0] = 4'd0;
      runCmd(1'($urandom), 1'($urandom), 2'($urandom), 3'($urandom), 1'($urandom),
             5'($urandom), ($urandom % 3 == 0) ? 5'd31 : 5'($urandom), int'($urandom % 60));
    end
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule